// File: doc/BRIEF.md
# Parallel Word Memory Responder

This block plays the device side of an asynchronous parallel word-wide memory bus in synthesizable form, so that a memory controller can be verified against it. A fast sampling clock oversamples the active-low chip enable, write enable, output enable and the two byte enables, along with the address and the incoming data. The block serves accesses out of an internal array of 16-bit words. The address splits into a row part and a column part. The row is captured when chip enable falls. The column bits may change while chip enable stays low, which gives page-mode accesses with a shorter access time.

The block decides cycle by cycle whether to drive each data byte. It withholds the bus until the access has completed. It never drives while write enable is low, and a cycle that began as a read gives up the bus for good once a write starts in it. Writes go straight into the array when the write ends. There is no busy state and nothing to poll. The pad is modelled as a data output plus one drive enable per byte.

Top module: `pmem_responder`

## Requirements
- R1: A chip-enable falling edge, once seen through the synchronizer, opens an access at the row and column on the address pins. The access is a read if write enable is high at that point and a write if write enable is already low.
- R2: The upper byte is driven (dq_oe[1]) only while chip enable, output enable and the upper byte enable are all low. The lower byte (dq_oe[0]) follows the same rule with the lower byte enable.
- R3: After chip enable falls, neither byte is driven until ACC_CYC cycles after the fall is seen. If output enable is already low, the bus stays released until then and is driven with the stored word from that cycle on.
- R4: While write enable is low, neither byte is driven, whatever the state of output enable.
- R5: In a cycle that began as a read, a fall of write enable releases the bus. The bus stays released until the next chip-enable falling edge.
- R6: A write commits the data and column present on the pins at the earlier of write enable rising and chip enable rising. Data changes before that point have no effect.
- R7: A write updates only the bytes whose enables are low at the commit point. Upper is dq[15:8] and lower is dq[7:0].
- R8: In a read, a change of the column bits (addr[1:0]) while chip enable stays low releases the bus. The word at the new column is then driven PAGE_CYC cycles after the change is seen.
- R9: Changes on the row bits (addr[ADDR_W-1:2]) while chip enable stays low are ignored until the next chip-enable falling edge.
- R10: A write whose write enable is low before chip enable falls commits when chip enable rises. Several write-enable pulses within one chip-enable-low cycle each write the column present at their own rising edge.
- R11: Every pin passes two synchronizing flops. An output reacts right after the second rising clock edge that follows a pin change.
- R12: While rst_n is low, both byte drive enables are 0 and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ce_n | input | 1 | chip enable, active low |
| we_n | input | 1 | write enable, active low |
| oe_n | input | 1 | output enable, active low |
| ub_n | input | 1 | upper byte enable, active low |
| lb_n | input | 1 | lower byte enable, active low |
| addr | input | ADDR_W | word address, low COL_W bits are the column |
| dq_in | input | 16 | data from the bus |
| dq_out | output | 16 | word at the open row and column |
| dq_oe | output | 2 | per-byte drive enable, bit 1 upper |

## Verification
The bench targets output enable going low early. A design that drove before the access time would put stale words on the bus. Column changes during a read are also tested: without the release window, the old column's word would appear for a cycle after the change. Data is changed between the write-enable fall and its rise, so a design that captured at the fall would store the wrong value. A read cycle turned into a write is also exercised; a responder that resumed driving after the write pulse would then collide with the controller.

// File: rtl/pmem_responder.sv
module pmem_responder #(
  parameter int ADDR_W   = 8,
  parameter int COL_W    = 2,
  parameter int ACC_CYC  = 6,
  parameter int PAGE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [1:0]        dq_oe
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SW    = 5 + ADDR_W + 16;
  localparam int MAXC  = (ACC_CYC > PAGE_CYC) ? ACC_CYC : PAGE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [SW-1:0] IDLE = {5'b11111, {(SW-5){1'b0}}};

  logic [SW-1:0] s1, s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
    end else begin
      s1 <= {ce_n, we_n, oe_n, ub_n, lb_n, addr, dq_in};
      s2 <= s1;
    end

  logic              c_ce, c_we, c_oe, c_ub, c_lb;
  logic [ADDR_W-1:0] c_addr;
  logic [15:0]       c_din;
  assign {c_ce, c_we, c_oe, c_ub, c_lb, c_addr, c_din} = s2;

  logic             p_ce, p_we, active, rd;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [CNT_W-1:0] cnt;
  logic             ce_fall, wr_end, ready;

  assign ce_fall = p_ce & ~c_ce;
  assign wr_end  = active & ~p_we & (c_we | c_ce);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_ce   <= 1'b1;
      p_we   <= 1'b1;
      active <= 1'b0;
      rd     <= 1'b0;
      row    <= '0;
      col    <= '0;
      cnt    <= '0;
    end else begin
      p_ce <= c_ce;
      p_we <= c_we;
      if (c_ce) begin
        active <= 1'b0;
      end else if (ce_fall) begin
        active <= 1'b1;
        row    <= c_addr[ADDR_W-1:COL_W];
        col    <= c_addr[COL_W-1:0];
        rd     <= c_we;
        cnt    <= CNT_W'(ACC_CYC - 1);
      end else if (active) begin
        if (!c_we) rd <= 1'b0;
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (rd && c_we && c_addr[COL_W-1:0] != col) begin
          col <= c_addr[COL_W-1:0];
          cnt <= CNT_W'(PAGE_CYC - 1);
        end
      end
    end

  logic [15:0] mem [DEPTH];
  always_ff @(posedge clk)
    if (wr_end) begin
      if (!c_ub) mem[{row, c_addr[COL_W-1:0]}][15:8] <= c_din[15:8];
      if (!c_lb) mem[{row, c_addr[COL_W-1:0]}][7:0]  <= c_din[7:0];
    end

  assign ready  = active & (cnt == '0) & ~c_ce & (c_addr[COL_W-1:0] == col)
                & rd & c_we & ~c_oe;
  assign dq_oe  = {ready & ~c_ub, ready & ~c_lb};
  assign dq_out = mem[{row, col}];
endmodule

module pmem_responder_sva #(
  parameter int ACC_CYC = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       ub_n,
  input logic       lb_n,
  input logic [1:0] dq_oe
);
  localparam int CW = $clog2(ACC_CYC + 1);
  logic          ce_d1, ce_d2;
  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_d1  <= 1'b1;
      ce_d2  <= 1'b1;
      lo_cnt <= '0;
    end else begin
      ce_d1 <= ce_n;
      ce_d2 <= ce_d1;
      if (ce_d2) lo_cnt <= '0;
      else if (lo_cnt != CW'(ACC_CYC)) lo_cnt <= lo_cnt + 1'b1;
    end

  AST_WAIT_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> (lo_cnt == CW'(ACC_CYC))); // R3
  AST_NO_DRIVE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> $past(we_n, 2)); // R4
  AST_UPPER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[1] |-> (!$past(ub_n, 2) && !$past(oe_n, 2))); // R2
  AST_LOWER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> (!$past(lb_n, 2) && !$past(oe_n, 2))); // R2
  AST_CE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n, 2) |-> (dq_oe == 2'b00)); // R2
endmodule

bind pmem_responder pmem_responder_sva #(.ACC_CYC(ACC_CYC)) u_sva (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .ub_n(ub_n), .lb_n(lb_n), .dq_oe(dq_oe)
);

// File: tb/test_pmem_responder.sv
module test_pmem_responder;
  localparam int ACC  = 6;
  localparam int PAGE = 2;

  typedef struct packed {
    logic ce, we, oe, ub, lb;
    logic [7:0] a;
    logic [15:0] d;
  } pins_t;
  localparam pins_t IDLE = '{ce: 1'b1, we: 1'b1, oe: 1'b1, ub: 1'b1, lb: 1'b1, a: 8'h0, d: 16'h0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1, we_n = 1, oe_n = 1, ub_n = 1, lb_n = 1;
  logic [7:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out;
  logic [1:0] dq_oe;
  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R12";

  always #10 clk = ~clk;

  pmem_responder #(.ADDR_W(8), .COL_W(2), .ACC_CYC(ACC), .PAGE_CYC(PAGE)) i_pmem_responder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n),
    .lb_n(lb_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  pins_t q[$];
  logic [15:0] mmem [256];
  bit m_act, m_rd;
  int m_cnt;
  logic [5:0] m_row;
  logic [1:0] m_col;
  logic [1:0] e_oe = 2'b00;
  logic [15:0] e_dat = '0;

  always @(posedge clk) begin
    pins_t cur, prv, c;
    bit rdy;
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < 3; i++) q.push_back(IDLE);
      m_act = 0; m_rd = 0; m_cnt = 0;
    end else begin
      q.push_back('{ce: ce_n, we: we_n, oe: oe_n, ub: ub_n, lb: lb_n, a: addr, d: dq_in});
      if (q.size() > 4) void'(q.pop_front());
      cur = q[1];
      prv = q[0];
      if (m_act && !prv.we && (cur.we || cur.ce)) begin
        if (!cur.ub) mmem[{m_row, cur.a[1:0]}][15:8] = cur.d[15:8];
        if (!cur.lb) mmem[{m_row, cur.a[1:0]}][7:0] = cur.d[7:0];
      end
      if (cur.ce) m_act = 0;
      else if (prv.ce) begin
        m_act = 1; m_row = cur.a[7:2]; m_col = cur.a[1:0]; m_rd = cur.we; m_cnt = ACC - 1;
      end else if (m_act) begin
        if (m_cnt > 0) m_cnt--;
        else if (m_rd && cur.we && cur.a[1:0] != m_col) begin
          m_col = cur.a[1:0]; m_cnt = PAGE - 1;
        end
        if (!cur.we) m_rd = 0;
      end
    end
    c = q[q.size() - 2];
    rdy = rst_n && m_act && m_cnt == 0 && !c.ce && c.a[1:0] == m_col && m_rd && c.we && !c.oe;
    e_oe = {rdy && !c.ub, rdy && !c.lb};
    e_dat = mmem[{m_row, m_col}];
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (dq_oe !== e_oe || (dq_oe[1] && dq_out[15:8] !== e_dat[15:8])
        || (dq_oe[0] && dq_out[7:0] !== e_dat[7:0])) begin
      errors++;
      $display("FAIL %s model: oe=%b dat=%h expected oe=%b dat=%h", phase, dq_oe, dq_out, e_oe, e_dat);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_we(input logic [7:0] a, input logic [15:0] d0, input logic [15:0] d,
                       input logic u, input logic l);
    ce_n = 0; we_n = 1; oe_n = 1; addr = a; tick(3);
    we_n = 0; ub_n = u; lb_n = l; dq_in = d0; tick(2);
    dq_in = d; tick(2);
    we_n = 1; tick(3);
    ce_n = 1; ub_n = 1; lb_n = 1; tick(4);
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    ce_n = 0; we_n = 1; oe_n = 0; ub_n = 0; lb_n = 0; addr = a;
    tick(ACC + 1); chk("R3", {dq_oe, dq_out & 16'h0}, 18'h0);
    tick(1); chk(tag, {dq_oe, dq_out}, {2'b11, exp});
    ce_n = 1; oe_n = 1; ub_n = 1; lb_n = 1; tick(4);
  endtask

  initial begin
    tick(5);
    chk("R12", {dq_oe, 16'h0}, 18'h0);
    rst_n = 1; tick(3);

    phase = "R6";
    wr_we(8'h10, 16'h1111, 16'h1234, 0, 0);
    phase = "R10";
    we_n = 0; ub_n = 0; lb_n = 0; oe_n = 0; addr = 8'h11; dq_in = 16'h5678; tick(2);
    ce_n = 0; tick(ACC + 4);
    chk("R4", {dq_oe, 16'h0}, 18'h0);
    ce_n = 1; tick(3); we_n = 1; oe_n = 1; ub_n = 1; lb_n = 1; tick(4);
    phase = "R10";
    ce_n = 0; we_n = 1; addr = 8'h13; tick(3);
    we_n = 0; ub_n = 0; lb_n = 0; dq_in = 16'h9ABC; tick(3); we_n = 1; tick(3);
    addr = 8'h12; dq_in = 16'hDEF0; we_n = 0; tick(3); we_n = 1; tick(3);
    ce_n = 1; ub_n = 1; lb_n = 1; tick(4);
    phase = "R9";
    wr_we(8'h51, 16'h0F0F, 16'h0F0F, 0, 0);

    phase = "R3";
    ce_n = 0; we_n = 1; oe_n = 0; ub_n = 0; lb_n = 0; addr = 8'h10;
    tick(ACC + 1); chk("R3", {dq_oe, 16'h0}, 18'h0);
    tick(1); chk("R6", {dq_oe, dq_out}, {2'b11, 16'h1234});
    phase = "R11";
    oe_n = 1; tick(1); chk("R11", {dq_oe, 16'h0}, {2'b11, 16'h0});
    tick(1); chk("R11", {dq_oe, 16'h0}, 18'h0);
    oe_n = 0; tick(2); chk("R11", {dq_oe, 16'h0}, {2'b11, 16'h0});
    phase = "R2";
    ub_n = 1; tick(2); chk("R2", {dq_oe, 16'h0}, {2'b01, 16'h0});
    ub_n = 0; lb_n = 1; tick(2); chk("R2", {dq_oe, 16'h0}, {2'b10, 16'h0});
    lb_n = 0; tick(2);
    phase = "R8";
    addr = 8'h11; tick(PAGE + 1); chk("R8", {dq_oe, 16'h0}, 18'h0);
    tick(1); chk("R8", {dq_oe, dq_out}, {2'b11, 16'h5678});
    phase = "R9";
    addr = 8'h51; tick(6); chk("R9", {dq_oe, dq_out}, {2'b11, 16'h5678});
    addr = 8'h11;
    phase = "R5";
    dq_in = 16'h5678; we_n = 0; tick(2); chk("R4", {dq_oe, 16'h0}, 18'h0);
    we_n = 1; tick(4); chk("R5", {dq_oe, 16'h0}, 18'h0);
    ce_n = 1; oe_n = 1; ub_n = 1; lb_n = 1; tick(4);

    phase = "R7";
    wr_we(8'h10, 16'hAAAA, 16'hAAAA, 1, 0);
    rd(8'h10, 16'h12AA, "R7");
    phase = "R10";
    rd(8'h11, 16'h5678, "R10");
    rd(8'h12, 16'hDEF0, "R10");
    rd(8'h13, 16'h9ABC, "R10");
    phase = "R1";
    rd(8'h51, 16'h0F0F, "R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule